// File: doc/BRIEF.md
# Table-Driven Multi-Output Clock Divider

This block runs on one fast source clock and produces five clock-enable outputs: core, bus, peripheral, memory and display. Each enable is a one-cycle pulse that repeats every N source cycles. N comes from a fixed, non-uniform ratio table (1, 2, 3, 4, 6, 8, 12, 16, 24, 32). A small field in a shared control word picks the table entry. Downstream logic uses these pulses to advance slower domains that stay synchronous to the source clock.

Software writes the control word through a single write strobe and reads it back on a parallel output. A change-enable bit in the word sets whether new field values reach the counters. When the bit is set, each lane picks up its new ratio only at its own terminal count, so the period in progress always completes. A half-rate select puts a divide-by-two stage in front of the display lane.

Top module: `clkdiv_table`

## Requirements
- R1: While rst_ni is low, and right after it rises, the control word reads zero and every lane runs at ratio 1, so all enable bits are high.
- R2: Field index k selects ratio 1, 2, 3, 4, 6, 8, 12, 16, 24, 32 for k = 0..9. An active ratio N gives one single-cycle enable pulse every N source cycles.
- R3: Any field index above 9 (10..15 in a 4-bit field, 10..31 in the 5-bit field) selects ratio 32.
- R4: Field positions in the control word: core bits 3:0 drive div_en_o[0], bus bits 7:4 drive div_en_o[1], peripheral bits 11:8 drive div_en_o[2], memory bits 15:12 drive div_en_o[3], and the 5-bit display field at bits 20:16 drives div_en_o[4].
- R5: While change-enable (bit 22) is 0, writes update the stored word, but every lane keeps its active ratio.
- R6: While change-enable is 1, a lane loads the ratio from its field only at the edge that ends its current period. The period in progress is never cut short.
- R7: When bit 21 is 1, the display lane counts only every second source cycle, so its enable period is twice its ratio and no two display pulses are adjacent.
- R8: ctrl_o returns bits 22:0 of the last written word. Bits 31:23 always read 0.
- R9: A lane with active ratio 1 and no half-rate stage keeps its enable high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| ctrl_o | output | 32 | Stored control word readback |
| div_en_o | output | 5 | Enables: [0] core, [1] bus, [2] peripheral, [3] memory, [4] display |

## Verification
The bench builds the block with its default parameters: four 4-bit main fields, one 5-bit display field and a largest ratio of 32. With these, every table entry, the index-overflow range of both field widths, and the longest period are all reachable within a few hundred cycles. The scoreboard models each lane's period from the table. Ratio changes are issued in the middle of a period, both with change-enable clear and with it set, so the hold and the apply-at-terminal-count rules are both exercised. The half-rate stage is tested together with display ratios 1 and 3.

// File: rtl/clkdiv_table_pkg.sv
package clkdiv_table_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_MAIN  = 4;
  localparam int MAIN_FW   = 4;
  localparam int DISP_FW   = 5;
  localparam int DISP_POS  = NUM_MAIN * MAIN_FW;
  localparam int HALF_BIT  = 21;
  localparam int CE_BIT    = 22;
  localparam int REG_W     = CE_BIT + 1;
  localparam int NUM_OUT   = NUM_MAIN + 1;
  localparam int TBL_LEN   = 10;
  localparam int MAX_RATIO = 32;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

  // entries alternate 2<<k / 3<<k after the leading 1
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [7:0] idx);
    int k;
    if (idx == 8'd0) return RATIO_W'(1);
    if (idx >= 8'(TBL_LEN)) return RATIO_W'(MAX_RATIO);
    k = (int'(idx) - 1) >> 1;
    if (idx[0]) return RATIO_W'(2 << k);
    return RATIO_W'(3 << k);
  endfunction
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [REG_W-1:0]  ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i[REG_W-1:0];
  end

  assign ctrl_o = ctrl_q;

  logic unused_hi;
  assign unused_hi = ^wr_data_i[DATA_W-1:REG_W];
endmodule

// File: rtl/clkdiv_half_gen.sv
module clkdiv_half_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic tick_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign tick_o = ~sel_i | ph_q;
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
  import clkdiv_table_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               ce_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               en_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] act_q, cnt_q, next_ratio;
  logic               term;

  assign next_ratio = ratio_of(8'(field_i));
  assign term       = (cnt_q == act_q - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RATIO_W'(1);
      cnt_q <= '0;
    end else if (tick_i) begin
      if (term) begin
        cnt_q <= '0;
        if (ce_i) act_q <= next_ratio;
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  assign en_o    = tick_i & term;
  assign ratio_o = act_q;
endmodule

// File: rtl/clkdiv_table.sv
module clkdiv_table
  import clkdiv_table_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [NUM_OUT-1:0] div_en_o
);
  logic [REG_W-1:0]           ctrl_q;
  logic                       disp_tick;
  logic [NUM_OUT*RATIO_W-1:0] act_all;

  clkdiv_ctrl_reg #(.DATA_W(DATA_W), .REG_W(REG_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_q)
  );

  assign ctrl_o = DATA_W'(ctrl_q);

  clkdiv_half_gen u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (ctrl_q[HALF_BIT]),
    .tick_o (disp_tick)
  );

  for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
    clkdiv_lane #(.FIELD_W(MAIN_FW)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (1'b1),
      .ce_i    (ctrl_q[CE_BIT]),
      .field_i (ctrl_q[g*MAIN_FW +: MAIN_FW]),
      .en_o    (div_en_o[g]),
      .ratio_o (act_all[g*RATIO_W +: RATIO_W])
    );
  end

  clkdiv_lane #(.FIELD_W(DISP_FW)) u_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (disp_tick),
    .ce_i    (ctrl_q[CE_BIT]),
    .field_i (ctrl_q[DISP_POS +: DISP_FW]),
    .en_o    (div_en_o[NUM_MAIN]),
    .ratio_o (act_all[NUM_MAIN*RATIO_W +: RATIO_W])
  );
endmodule

// File: rtl/clkdiv_table_chk.sv
module clkdiv_table_chk
  import clkdiv_table_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic [DATA_W-1:0]          ctrl_o,
  input logic [NUM_OUT-1:0]         div_en_o,
  input logic [NUM_OUT*RATIO_W-1:0] act_all
);
  p_readback_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_o[REG_W-1:0] == $past(wr_data_i[REG_W-1:0]));

  p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[DATA_W-1:REG_W] == '0);

  p_hold_ratio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[CE_BIT] |=> $stable(act_all));

  p_half_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[HALF_BIT] && div_en_o[NUM_MAIN] && !wr_en_i) |=> !div_en_o[NUM_MAIN]);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    p_apply_at_term_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !div_en_o[g] |=> $stable(act_all[g*RATIO_W +: RATIO_W]));
  end

  for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
    p_ratio_one_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_all[g*RATIO_W +: RATIO_W] == RATIO_W'(1) |-> div_en_o[g]);
  end
endmodule

bind clkdiv_table clkdiv_table_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .ctrl_o    (ctrl_o),
  .div_en_o  (div_en_o),
  .act_all   (act_all)
);

// File: tb/clkdiv_table_tb.sv
`timescale 1ns/1ps
module clkdiv_table_tb;
  localparam int NO = 5;
  localparam logic [31:0] MASK = 32'h007F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl;
  logic [NO-1:0] div_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1 R9";

  always #2.5 clk = ~clk;

  clkdiv_table u_dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .ctrl_o (ctrl), .div_en_o (div_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int tbl(input int idx);
    int t[10] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32};
    if (idx > 9) return 32;
    return t[idx];
  endfunction

  function automatic logic [31:0] mk(input int c, input int b, input int p, input int m,
                                     input int d, input bit half, input bit ce);
    return 32'(c & 15) | (32'(b & 15) << 4) | (32'(p & 15) << 8) | (32'(m & 15) << 12) |
           (32'(d & 31) << 16) | (32'(half) << 21) | (32'(ce) << 22);
  endfunction

  // scoreboard model: expected enables for the cycle after each edge
  logic [NO-1:0] exp_q[$];
  logic [31:0] m_reg;
  int m_cnt[NO];
  int m_act[NO];
  bit m_ph;

  function automatic int fld(input logic [31:0] r, input int i);
    if (i == 4) return int'(r[20:16]);
    return int'((r >> (4 * i)) & 32'hF);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit tk_d;
      logic [NO-1:0] e;
      tk_d = !m_reg[21] || m_ph;
      for (int i = 0; i < NO; i++) begin
        bit tk;
        tk = (i == 4) ? tk_d : 1'b1;
        if (tk) begin
          if (m_cnt[i] == m_act[i] - 1) begin
            m_cnt[i] = 0;
            if (m_reg[22]) m_act[i] = tbl(fld(m_reg, i));
          end else m_cnt[i]++;
        end
      end
      m_ph = !m_ph;
      if (wr_en) m_reg = wr_data & MASK;
      tk_d = !m_reg[21] || m_ph;
      for (int i = 0; i < NO; i++)
        e[i] = (m_cnt[i] == m_act[i] - 1) && ((i == 4) ? tk_d : 1'b1);
      exp_q.push_back(e);
    end else begin
      m_reg = '0; m_ph = 1'b0;
      for (int i = 0; i < NO; i++) begin m_cnt[i] = 0; m_act[i] = 1; end
    end
  end

  always @(negedge clk) begin
    if (!done && exp_q.size() > 0) begin
      logic [NO-1:0] e;
      e = exp_q.pop_front();
      chk({cur_req, " enables"}, 32'(div_en), 32'(e));
    end
  end

  task automatic wr(input logic [31:0] d, input string req);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    chk({req, " R8 readback"}, ctrl, d & MASK);
  endtask

  task automatic count_pulses(input int lane, input int cycles, input int exp, input string req);
    int n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (div_en[lane]) n++;
    end
    chk(req, 32'(n), 32'(exp));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", ctrl, 32'h0);
    chk("R1 reset enables", 32'(div_en), 32'h1F);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    cur_req = "R5";
    wr(mk(3, 4, 5, 6, 7, 1'b0, 1'b0), "R5");
    repeat (20) @(negedge clk);
    chk("R5 R9 ratios held at 1", 32'(div_en), 32'h1F);

    cur_req = "R2 R4 R6";
    wr(mk(1, 2, 4, 9, 6, 1'b0, 1'b1), "R6");
    repeat (40) @(negedge clk);
    count_pulses(0, 64, 32, "R2 R4 core ratio 2");
    count_pulses(3, 64, 2, "R2 R4 memory ratio 32");
    count_pulses(1, 66, 22, "R2 R4 bus ratio 3");
    repeat (30) @(negedge clk);
    wr(mk(5, 3, 7, 8, 8, 1'b0, 1'b1), "R6");
    repeat (120) @(negedge clk);

    cur_req = "R3";
    wr(mk(12, 15, 10, 11, 31, 1'b0, 1'b1), "R3");
    repeat (80) @(negedge clk);
    count_pulses(0, 96, 3, "R3 core index 12");
    count_pulses(4, 96, 3, "R3 display index 31");

    cur_req = "R7";
    wr(mk(0, 0, 0, 0, 0, 1'b1, 1'b1), "R7");
    repeat (50) @(negedge clk);
    count_pulses(4, 40, 20, "R7 display half ratio 1");
    chk("R9 core ratio 1", 32'(div_en[0]), 32'h1);
    wr(mk(0, 0, 0, 0, 2, 1'b1, 1'b1), "R7");
    repeat (20) @(negedge clk);
    count_pulses(4, 60, 10, "R7 display half ratio 3");

    cur_req = "R5";
    wr(mk(2, 2, 2, 2, 2, 1'b0, 1'b1), "R6");
    repeat (7) @(negedge clk);
    wr(mk(9, 9, 9, 9, 9, 1'b0, 1'b0), "R5");
    repeat (24) @(negedge clk);
    count_pulses(0, 60, 20, "R5 core keeps ratio 3");

    cur_req = "R8";
    wr(32'hFFFF_FFFF, "R8");
    chk("R8 reserved bits", ctrl & ~MASK, 32'h0);
    repeat (80) @(negedge clk);

    finish_run();
  end
endmodule